// File: doc/BRIEF.md
# Multi-Issue Dependency Pending Tracker

This block keeps, for every functional unit (FU) of an out-of-order core, a record of which other FUs the instruction parked in it still waits on. Each FU owns two rows of flops, a read-wait row and a write-wait row, with one bit per FU in the machine. Bit `c` of row `f` set means "the instruction in FU `f` waits on the instruction in FU `c`". When a row pair holds no set bit, the FU's ready output rises and the instruction may proceed.

Up to four instructions issue together, slot 0 being the oldest. An issuing slot loads its target FU's rows with the union of its own dependence vectors and those of every older valid slot in the same group, so the dependence is transitive. The youngest slot therefore carries the largest set and the oldest the smallest. The rows are loaded only from the issue inputs, never from same-cycle values of other rows, so two instructions issued together cannot hold each other up in a loop.

Bits are dropped by three relax strobes, each an FU-indexed vector with at most one set bit. One drops a read wait (operand read done). One drops a write wait (result written). One drops both (the awaited operation is complete: an address compare found no clash, or a branch was confirmed). No enumerated state machine exists: each FU's state is its pair of rows, held in flops under an active-low reset.

Top module: `dep_pend_tracker`

## Requirements
- R1: After reset, every read-wait and write-wait bit is 0 and every `fu_ready` bit is 1.
- R2: A valid issue slot replaces the whole row pair of its target FU at the next clock edge; no bit of the previous contents remains. Row `f` bit `c` appears at `rd_pend[f*8+c]` and `wr_pend[f*8+c]`; slot `s` uses `iss_fu[s*3+:3]`, `iss_rd[s*8+:8]` and `iss_wr[s*8+:8]`.
- R3: The row loaded by slot `s` equals the OR of the dependence vectors of all valid slots `0..s`. Invalid slots contribute nothing, so a younger slot always holds a superset of an older slot's set.
- R4: The bit of a row that names its own FU is never stored.
- R5: `rel_rd[c]` clears bit `c` of every read-wait row that is not loaded in that cycle and leaves write-wait rows alone. Each relax vector carries at most one set bit.
- R6: `rel_wr[c]` clears bit `c` of every write-wait row that is not loaded in that cycle and leaves read-wait rows alone.
- R7: `rel_done[c]` clears bit `c` in both rows of every FU that is not loaded in that cycle.
- R8: When an FU is loaded in the same cycle as a relax of a bit in its new contents, the bit stays set (set wins).
- R9: When two valid slots target the same FU in one cycle, the younger slot's contents are kept.
- R10: `fu_ready[f]` is 1 exactly when both rows of FU `f` are all zero.
- R11: With no issue and no relax, all rows hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 4 | Issue slot valid, slot 0 oldest |
| iss_fu | input | 12 | Target FU per slot, 3 bits each |
| iss_rd | input | 32 | Read dependence vector per slot, 8 bits each |
| iss_wr | input | 32 | Write dependence vector per slot, 8 bits each |
| rel_rd | input | 8 | Read-wait relax, one bit per awaited FU |
| rel_wr | input | 8 | Write-wait relax, one bit per awaited FU |
| rel_done | input | 8 | Completion relax, clears both kinds |
| rd_pend | output | 64 | Read-wait rows, 8 bits per FU |
| wr_pend | output | 64 | Write-wait rows, 8 bits per FU |
| fu_ready | output | 8 | FU has no pending wait |

## Verification
Directed groups come first. A lone issue shows capture and replacement. A four-slot group with disjoint vectors makes the triangle visible bit by bit, and gaps in slot validity separate "older valid slots" from "all older slots". A slot that names its own FU and two slots aimed at one FU separate self-masking and younger-wins from a plain OR. Each relax kind is then applied alone, and then together with a load that sets the relaxed bit, which separates the row kinds and shows that set wins. A long random run, compared every clock against a bench model that recomputes each union from scratch, covers the mixed cases.

// File: rtl/dep_trk_pkg.sv
package dep_trk_pkg;
    localparam int unsigned DEF_NFU   = 8;
    localparam int unsigned DEF_NSLOT = 4;
endpackage

// File: rtl/dep_slot_merge.sv
module dep_slot_merge #(
    parameter int unsigned NFU   = dep_trk_pkg::DEF_NFU,
    parameter int unsigned NSLOT = dep_trk_pkg::DEF_NSLOT,
    localparam int unsigned FUW  = $clog2(NFU)
) (
    input  logic [NSLOT-1:0]     slot_vld,
    input  logic [NSLOT*FUW-1:0] slot_fu,
    input  logic [NSLOT*NFU-1:0] slot_rd,
    input  logic [NSLOT*NFU-1:0] slot_wr,
    output logic [NFU-1:0]       row_ld,
    output logic [NFU*NFU-1:0]   row_rd,
    output logic [NFU*NFU-1:0]   row_wr
);
    logic [NFU-1:0] acc_rd, acc_wr;
    logic [NFU-1:0] eff_rd [NSLOT];
    logic [NFU-1:0] eff_wr [NSLOT];
    logic [FUW-1:0] tgt;

    // Running union over older valid slots; later slots overwrite earlier ones.
    always_comb begin
        acc_rd = '0;
        acc_wr = '0;
        row_ld = '0;
        row_rd = '0;
        row_wr = '0;
        tgt    = '0;
        for (int s = 0; s < NSLOT; s++) begin
            eff_rd[s] = '0;
            eff_wr[s] = '0;
            if (slot_vld[s]) begin
                acc_rd    = acc_rd | slot_rd[s*NFU +: NFU];
                acc_wr    = acc_wr | slot_wr[s*NFU +: NFU];
                eff_rd[s] = acc_rd;
                eff_wr[s] = acc_wr;
                tgt       = slot_fu[s*FUW +: FUW];
                row_ld[tgt] = 1'b1;
                row_rd[int'(tgt)*NFU +: NFU] = acc_rd & ~(NFU'(1) << tgt);
                row_wr[int'(tgt)*NFU +: NFU] = acc_wr & ~(NFU'(1) << tgt);
            end
        end
    end

    // R3
    always_comb begin
        for (int j = 0; j < NSLOT; j++) begin
            for (int k = j + 1; k < NSLOT; k++) begin
                if (slot_vld[j] && slot_vld[k]) begin
                    tri_chk: assert (((eff_rd[j] & ~eff_rd[k]) == '0) &&
                                     ((eff_wr[j] & ~eff_wr[k]) == '0));
                end
            end
        end
    end

    // R4
    always_comb begin
        for (int f = 0; f < NFU; f++) begin
            self_chk: assert (!row_rd[f*NFU+f] && !row_wr[f*NFU+f]);
        end
    end
endmodule

// File: rtl/dep_row.sv
module dep_row #(
    parameter int unsigned NFU = dep_trk_pkg::DEF_NFU
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [NFU-1:0] ld_rd,
    input  logic [NFU-1:0] ld_wr,
    input  logic [NFU-1:0] clr_rd,
    input  logic [NFU-1:0] clr_wr,
    output logic [NFU-1:0] rd_q,
    output logic [NFU-1:0] wr_q,
    output logic           ready
);
    // A load replaces the row outright, so it wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else if (ld) begin
            rd_q <= ld_rd;
            wr_q <= ld_wr;
        end else begin
            rd_q <= rd_q & ~clr_rd;
            wr_q <= wr_q & ~clr_wr;
        end
    end

    always_comb ready = (rd_q == '0) && (wr_q == '0);

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (rd_q == $past(ld_rd)) && (wr_q == $past(ld_wr)));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ((rd_q & $past(clr_rd)) == '0) && ((wr_q & $past(clr_wr)) == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && clr_rd == '0 && clr_wr == '0) |=> $stable(rd_q) && $stable(wr_q));

    // R11
    noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ((rd_q & ~$past(rd_q)) == '0) && ((wr_q & ~$past(wr_q)) == '0));
endmodule

// File: rtl/dep_pend_tracker.sv
module dep_pend_tracker #(
    parameter int unsigned NFU   = dep_trk_pkg::DEF_NFU,
    parameter int unsigned NSLOT = dep_trk_pkg::DEF_NSLOT,
    localparam int unsigned FUW  = $clog2(NFU)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSLOT-1:0]     iss_vld,
    input  logic [NSLOT*FUW-1:0] iss_fu,
    input  logic [NSLOT*NFU-1:0] iss_rd,
    input  logic [NSLOT*NFU-1:0] iss_wr,
    input  logic [NFU-1:0]       rel_rd,
    input  logic [NFU-1:0]       rel_wr,
    input  logic [NFU-1:0]       rel_done,
    output logic [NFU*NFU-1:0]   rd_pend,
    output logic [NFU*NFU-1:0]   wr_pend,
    output logic [NFU-1:0]       fu_ready
);
    logic [NFU-1:0]     row_ld;
    logic [NFU*NFU-1:0] row_rd, row_wr;
    logic [NFU-1:0]     clr_rd, clr_wr;

    always_comb begin
        clr_rd = rel_rd | rel_done;
        clr_wr = rel_wr | rel_done;
    end

    dep_slot_merge #(.NFU(NFU), .NSLOT(NSLOT)) u_merge (
        .slot_vld (iss_vld),
        .slot_fu  (iss_fu),
        .slot_rd  (iss_rd),
        .slot_wr  (iss_wr),
        .row_ld   (row_ld),
        .row_rd   (row_rd),
        .row_wr   (row_wr)
    );

    for (genvar f = 0; f < NFU; f++) begin : g_row
        dep_row #(.NFU(NFU)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (row_ld[f]),
            .ld_rd  (row_rd[f*NFU +: NFU]),
            .ld_wr  (row_wr[f*NFU +: NFU]),
            .clr_rd (clr_rd),
            .clr_wr (clr_wr),
            .rd_q   (rd_pend[f*NFU +: NFU]),
            .wr_q   (wr_pend[f*NFU +: NFU]),
            .ready  (fu_ready[f])
        );
    end

    // R5
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_rd) && $onehot0(rel_wr) && $onehot0(rel_done));

    // R10
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ld == '0 && $countones(fu_ready) < NFU) |=>
            ($countones(fu_ready) >= $countones($past(fu_ready))));
endmodule

// File: tb/dep_pend_tracker_bench.sv
module dep_pend_tracker_bench;
    localparam int NFU = 8;
    localparam int NSLOT = 4;
    localparam int FUW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    bit             b_vld [NSLOT];
    int             b_fu  [NSLOT];
    logic [NFU-1:0] b_rd  [NSLOT];
    logic [NFU-1:0] b_wr  [NSLOT];
    logic [NFU-1:0] b_rel_rd = '0, b_rel_wr = '0, b_rel_done = '0;

    logic [NSLOT-1:0]     iss_vld;
    logic [NSLOT*FUW-1:0] iss_fu;
    logic [NSLOT*NFU-1:0] iss_rd, iss_wr;
    logic [NFU*NFU-1:0]   rd_pend, wr_pend;
    logic [NFU-1:0]       fu_ready;

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            iss_vld[s]              = b_vld[s];
            iss_fu[s*FUW +: FUW]    = b_fu[s][FUW-1:0];
            iss_rd[s*NFU +: NFU]    = b_rd[s];
            iss_wr[s*NFU +: NFU]    = b_wr[s];
        end
    end

    dep_pend_tracker u_dep_pend_tracker (
        .clk(clk), .rst_n(rst_n),
        .iss_vld(iss_vld), .iss_fu(iss_fu), .iss_rd(iss_rd), .iss_wr(iss_wr),
        .rel_rd(b_rel_rd), .rel_wr(b_rel_wr), .rel_done(b_rel_done),
        .rd_pend(rd_pend), .wr_pend(wr_pend), .fu_ready(fu_ready)
    );

    bit m_rd [NFU][NFU];
    bit m_wr [NFU][NFU];
    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    task automatic clear_inputs();
        for (int s = 0; s < NSLOT; s++) begin
            b_vld[s] = 0; b_fu[s] = 0; b_rd[s] = '0; b_wr[s] = '0;
        end
        b_rel_rd = '0; b_rel_wr = '0; b_rel_done = '0;
    endtask

    task automatic compare();
        for (int f = 0; f < NFU; f++) begin
            logic [NFU-1:0] er, ew;
            for (int c = 0; c < NFU; c++) begin
                er[c] = m_rd[f][c];
                ew[c] = m_wr[f][c];
            end
            total++;
            if (rd_pend[f*NFU +: NFU] !== er || wr_pend[f*NFU +: NFU] !== ew) begin
                bad++;
                $display("FAIL %s fu=%0d rd=%b/%b wr=%b/%b (actual/expected)",
                         cur_req, f, rd_pend[f*NFU +: NFU], er, wr_pend[f*NFU +: NFU], ew);
            end
            total++;
            if (fu_ready[f] !== (er == '0 && ew == '0)) begin
                bad++;
                $display("FAIL R10 fu=%0d ready actual=%b expected=%b",
                         f, fu_ready[f], (er == '0 && ew == '0));
            end
        end
    endtask

    // Drive current inputs through one edge, update the model, check at negedge.
    task automatic step();
        bit nr [NFU][NFU];
        bit nw [NFU][NFU];
        for (int f = 0; f < NFU; f++)
            for (int c = 0; c < NFU; c++) begin
                nr[f][c] = m_rd[f][c] && !b_rel_rd[c] && !b_rel_done[c];
                nw[f][c] = m_wr[f][c] && !b_rel_wr[c] && !b_rel_done[c];
            end
        for (int s = 0; s < NSLOT; s++) begin
            if (b_vld[s]) begin
                for (int c = 0; c < NFU; c++) begin
                    bit ur = 0, uw = 0;
                    for (int j = 0; j <= s; j++)
                        if (b_vld[j]) begin
                            if (b_rd[j][c]) ur = 1;
                            if (b_wr[j][c]) uw = 1;
                        end
                    nr[b_fu[s]][c] = ur && (c != b_fu[s]);
                    nw[b_fu[s]][c] = uw && (c != b_fu[s]);
                end
            end
        end
        @(posedge clk);
        if (rst_n) begin
            m_rd = nr;
            m_wr = nw;
        end
        @(negedge clk);
        compare();
        clear_inputs();
    endtask

    task automatic put(int s, int fu, logic [NFU-1:0] rd, logic [NFU-1:0] wr);
        b_vld[s] = 1; b_fu[s] = fu; b_rd[s] = rd; b_wr[s] = wr;
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();

        // R2: lone issue, then replacement
        cur_req = "R2";
        put(0, 2, 8'b0001_0010, 8'b1000_0000); step();
        put(0, 2, 8'b0100_0000, 8'b0000_0001); step();

        // R3: full group with disjoint vectors, triangle
        cur_req = "R3";
        put(0, 4, 8'b0000_0001, 8'b0000_0000);
        put(1, 5, 8'b0000_0010, 8'b0000_1000);
        put(2, 6, 8'b0000_0000, 8'b0000_0100);
        put(3, 7, 8'b0000_1000, 8'b0000_0000); step();
        // R3: gaps in validity
        put(0, 0, 8'b0010_0000, 8'b0000_0000);
        put(2, 1, 8'b0000_0100, 8'b0001_0000);
        b_vld[1] = 0; b_rd[1] = 8'hff; b_wr[1] = 8'hff; step();

        // R4: own bit dropped
        cur_req = "R4";
        put(0, 3, 8'b0000_1001, 8'b0000_1000);
        put(1, 1, 8'b0000_0010, 8'b0000_0010); step();

        // R5, R6, R7: each relax kind alone
        cur_req = "R5"; b_rel_rd = 8'b0000_1000; step();
        cur_req = "R6"; b_rel_wr = 8'b0000_0100; step();
        cur_req = "R7"; b_rel_done = 8'b0000_0001; step();
        cur_req = "R11"; step(); step();

        // R8: load and relax of the same bit together
        cur_req = "R8";
        put(0, 6, 8'b0000_0010, 8'b0000_0010);
        b_rel_rd = 8'b0000_0010; b_rel_done = 8'b0000_0010; step();

        // R9: two slots on one FU
        cur_req = "R9";
        put(0, 5, 8'b0000_0001, 8'b0000_0000);
        put(2, 5, 8'b0100_0000, 8'b0000_0000); step();

        // R10: drain everything via completion relax
        cur_req = "R10";
        for (int c = 0; c < NFU; c++) begin
            b_rel_done = NFU'(1) << c; step();
        end

        // Random mix
        cur_req = "R3";
        for (int n = 0; n < 3000; n++) begin
            int k;
            for (int s = 0; s < NSLOT; s++)
                if ($urandom_range(0, 2) == 0)
                    put(s, $urandom_range(0, NFU-1), NFU'($urandom) & NFU'($urandom),
                        NFU'($urandom) & NFU'($urandom));
            k = $urandom_range(0, NFU); if (k < NFU) b_rel_rd = NFU'(1) << k;
            k = $urandom_range(0, NFU); if (k < NFU) b_rel_wr = NFU'(1) << k;
            k = $urandom_range(0, 2*NFU); if (k < NFU) b_rel_done = NFU'(1) << k;
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule